// File: doc/BRIEF.md
# Delayed Power-Good Pass-Through

This block sits between two board-level power-good signals and the matching inputs of a processor. One channel carries the resume-well power-good and the other carries the system power-OK. Each channel has its own output register. A falling input is forwarded straight away. A rising input is forwarded only after a minimum hold time has passed, so the processor never sees a power-good before its rails have settled.

Time is measured in pulses of a one-millisecond tick input. The hold time of each channel is the larger of a fixed floor and that channel's own delay parameter. The floor defaults to 10 ms and the per-channel delays default to 0, so by default the floor sets the hold. Both inputs arrive asynchronously and pass through a two-stage synchroniser before any decision is made.

For the power sequencer, the block reports whether each output currently agrees with its synchronised input. It also gives a one-cycle pulse whenever an output changes level.

Top module: `pg_passthru`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, both outputs go low, the edge pulses go low and any hold count in progress is cleared. After reset with both inputs low, `chan_match` reads 2'b11.
- R2: A falling input drives its output low on the third rising clock edge after the input changes: two edges of synchronisation and one edge of output register. The output must not fall earlier than that.
- R3: When the synchronised input is high and the output is low, the channel counts `ms_tick` pulses. The output goes high at the clock edge that samples the Nth such pulse, where N is the larger of `FLOOR_MS` and the channel's delay parameter. After N-1 pulses the output must still be low.
- R4: Each channel has its own delay parameter: `RSM_DELAY_MS` for channel 0 and `SYS_DELAY_MS` for channel 1. A delay below the floor has no effect. A delay above the floor lengthens the hold to that many ticks.
- R5: If the synchronised input falls while a hold count is running, the count is discarded and the output stays low. The next rise starts counting again from zero.
- R6: While a channel's output already equals its synchronised input, `ms_tick` pulses have no effect and the output does not change.
- R7: The two channels are independent. Activity on one channel, including its hold count, never changes the other channel's output.
- R8: `chan_match[0]` refers to the resume channel and `chan_match[1]` to the system channel. A bit is 1 when that channel's output equals its synchronised input.
- R9: `chan_edge[i]` is high for exactly one clock cycle: the first cycle in which output i shows its new level after a change. Bit 0 is the resume channel and bit 1 is the system channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| brd_rsm_pg | input | 1 | Board resume-well power-good (asynchronous) |
| brd_sys_pg | input | 1 | Board system power-good (asynchronous) |
| cpu_rsm_pg | output | 1 | Resume power-good to the processor |
| cpu_sys_pwrok | output | 1 | System power-OK to the processor |
| chan_match | output | 2 | Per-channel flag: output equals synchronised input |
| chan_edge | output | 2 | Per-channel one-cycle pulse when the output changes |

## Verification
The bench walks the two inputs through a sequence that covers several cases:
- Rises stopped one tick short of the hold, then completed, show that the floor and the longer per-channel delay are each honoured exactly.
- A rise cut short by a fall, followed by a fresh rise, shows whether the cancelled count was really cleared.
- Ticks applied while the inputs are steady, and steps where only one channel moves, separate a counter that runs freely from one that counts only while waiting, and show whether one channel leaks into the other.
- Directed cycle-exact checks on a falling edge, and a reset in the middle of a count, pin down the synchroniser latency and the single-cycle edge pulse.

// File: rtl/pg_passthru_pkg.sv
// Package: shared constants and types for the power-good pass-through.
// Assumes: every delay is expressed in millisecond ticks.
package pg_passthru_pkg;

    // Number of forwarded power-good channels.
    localparam int unsigned PG_CHANNELS = 2;

    // Channel index of each forwarded signal.
    localparam int unsigned CH_RSM = 0;
    localparam int unsigned CH_SYS = 1;

    // Per-channel sequencing state.
    typedef enum logic [1:0] {
        PG_LOW   = 2'b00,
        PG_ARMED = 2'b01,
        PG_HIGH  = 2'b10
    } pg_state_e;

    // Effective hold time: the larger of the floor and the requested delay.
    function automatic int unsigned pg_hold_ms(input int unsigned floor_ms,
                                               input int unsigned req_ms);
        return (req_ms > floor_ms) ? req_ms : floor_ms;
    endfunction

endpackage

// File: rtl/pg_sync.sv
// Module: multi-stage level synchroniser.
// Assumes: STAGES >= 2; d_async may change at any time; synchronous active-low reset.
module pg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pg_delay_chan.sv
// Module: one pass-through channel.
// A high synchronised level is forwarded after HOLD_MS tick pulses.
// A low level is forwarded on the next clock edge.
// Assumes: lvl_in is already synchronous; HOLD_MS >= 1; tick is one cycle wide.
module pg_delay_chan
    import pg_passthru_pkg::*;
#(
    parameter int unsigned HOLD_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl_in,
    output logic lvl_out,
    output logic lvl_edge
);

    localparam int unsigned CNT_W = (HOLD_MS < 2) ? 1 : $clog2(HOLD_MS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_MS - 1);

    pg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_d;

    // Next-state logic: arm on a rise, count ticks, and drop at once on a fall.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PG_LOW: begin
                cnt_d = '0;
                if (lvl_in) state_d = PG_ARMED;
            end
            PG_ARMED: begin
                if (!lvl_in) begin
                    state_d = PG_LOW;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = PG_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PG_HIGH: begin
                cnt_d = '0;
                if (!lvl_in) state_d = PG_LOW;
            end
            default: begin
                state_d = PG_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    assign out_d = (state_d == PG_HIGH);

    // State, counter, output register and change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PG_LOW;
            cnt_q    <= '0;
            lvl_out  <= 1'b0;
            lvl_edge <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            lvl_out  <= out_d;
            lvl_edge <= out_d ^ lvl_out;
        end
    end

endmodule

// File: rtl/pg_passthru.sv
// Module: top of the delayed power-good pass-through, two channels.
// Rising inputs wait max(FLOOR_MS, per-channel delay) ticks; falling inputs pass at once.
// Assumes: ms_tick is a single-cycle pulse; inputs are asynchronous to clk.
module pg_passthru
    import pg_passthru_pkg::*;
#(
    parameter int unsigned FLOOR_MS     = 10,
    parameter int unsigned RSM_DELAY_MS = 0,
    parameter int unsigned SYS_DELAY_MS = 0,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       brd_rsm_pg,
    input  logic       brd_sys_pg,
    output logic       cpu_rsm_pg,
    output logic       cpu_sys_pwrok,
    output logic [1:0] chan_match,
    output logic [1:0] chan_edge
);

    localparam int unsigned HOLD_RSM = pg_hold_ms(FLOOR_MS, RSM_DELAY_MS);
    localparam int unsigned HOLD_SYS = pg_hold_ms(FLOOR_MS, SYS_DELAY_MS);

    logic [PG_CHANNELS-1:0] raw_lvl;
    logic [PG_CHANNELS-1:0] sync_lvl;
    logic [PG_CHANNELS-1:0] out_vec;
    logic [PG_CHANNELS-1:0] edge_vec;

    assign raw_lvl[CH_RSM] = brd_rsm_pg;
    assign raw_lvl[CH_SYS] = brd_sys_pg;

    // One synchroniser and one delay channel per forwarded signal.
    for (genvar g = 0; g < PG_CHANNELS; g++) begin : g_chan
        localparam int unsigned HOLD_G = (g == CH_RSM) ? HOLD_RSM : HOLD_SYS;

        pg_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (raw_lvl[g]),
            .q_sync  (sync_lvl[g])
        );

        pg_delay_chan #(
            .HOLD_MS (HOLD_G)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ms_tick),
            .lvl_in   (sync_lvl[g]),
            .lvl_out  (out_vec[g]),
            .lvl_edge (edge_vec[g])
        );
    end

    assign cpu_rsm_pg    = out_vec[CH_RSM];
    assign cpu_sys_pwrok = out_vec[CH_SYS];
    assign chan_match    = ~(out_vec ^ sync_lvl);
    assign chan_edge     = edge_vec;

endmodule

// Module: property checker attached to every pg_passthru instance.
// Assumes: sync_lvl and out_lvl are the top's synchronised inputs and outputs.
module pg_passthru_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ms_tick,
    input logic [1:0] sync_lvl,
    input logic [1:0] out_lvl,
    input logic [1:0] chan_match,
    input logic [1:0] chan_edge
);

    for (genvar c = 0; c < 2; c++) begin : g_chk
        AST_FALL_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_lvl[c] && !sync_lvl[c]) |=> !out_lvl[c]); // R2

        AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_lvl[c]) |-> $past(ms_tick)); // R3

        AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_lvl[c]) |-> $past(sync_lvl[c])); // R3

        AST_LOW_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_lvl[c] && !sync_lvl[c]) |=> !out_lvl[c]); // R5

        AST_MATCH_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            chan_match[c] |=> $stable(out_lvl[c])); // R6

        AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            chan_edge[c] |=> !chan_edge[c]); // R9

        AST_EDGE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_lvl[c] != $past(out_lvl[c])) |-> chan_edge[c]); // R9
    end

endmodule

bind pg_passthru pg_passthru_chk u_pg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .sync_lvl   (sync_lvl),
    .out_lvl    (out_vec),
    .chan_match (chan_match),
    .chan_edge  (chan_edge)
);

// File: tb/pg_passthru_bench.sv
// Bench for pg_passthru: a vector walk, then directed reset and edge-timing tests.
module pg_passthru_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FLOOR      = 10;
    localparam int SYS_DLY    = 15;
    localparam int HOLD_R     = FLOOR;
    localparam int HOLD_S     = SYS_DLY;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       brd_rsm_pg = 1'b0;
    logic       brd_sys_pg = 1'b0;
    logic       cpu_rsm_pg;
    logic       cpu_sys_pwrok;
    logic [1:0] chan_match;
    logic [1:0] chan_edge;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_passthru #(
        .FLOOR_MS     (FLOOR),
        .RSM_DELAY_MS (0),
        .SYS_DELAY_MS (SYS_DLY),
        .SYNC_STAGES  (2)
    ) u_pg_passthru (
        .clk           (clk),
        .rst_n         (rst_n),
        .ms_tick       (ms_tick),
        .brd_rsm_pg    (brd_rsm_pg),
        .brd_sys_pg    (brd_sys_pg),
        .cpu_rsm_pg    (cpu_rsm_pg),
        .cpu_sys_pwrok (cpu_sys_pwrok),
        .chan_match    (chan_match),
        .chan_edge     (chan_edge)
    );

    // Vector: {rsm_in, sys_in, ticks[7:0], exp_rsm, exp_sys}
    typedef struct packed {
        logic       rsm;
        logic       sys;
        logic [7:0] ticks;
        logic       e_rsm;
        logic       e_sys;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'(HOLD_R-1), 1'b0, 1'b0}, // R3 one short of floor
        '{1'b1, 1'b0, 8'd1,         1'b1, 1'b0}, // R3 R4 floor reached
        '{1'b1, 1'b1, 8'(HOLD_S-1), 1'b1, 1'b0}, // R4 R7 longer delay, one short
        '{1'b1, 1'b1, 8'd1,         1'b1, 1'b1}, // R4 longer delay reached
        '{1'b0, 1'b1, 8'd0,         1'b0, 1'b1}, // R2 R7 fall without ticks
        '{1'b1, 1'b0, 8'd5,         1'b0, 1'b0}, // R2 partial count
        '{1'b0, 1'b0, 8'd0,         1'b0, 1'b0}, // R5 cancel
        '{1'b1, 1'b0, 8'(HOLD_R-1), 1'b0, 1'b0}, // R5 count restarted
        '{1'b1, 1'b0, 8'd1,         1'b1, 1'b0}, // R5 R3 completes
        '{1'b1, 1'b0, 8'd40,        1'b1, 1'b0}, // R6 steady high / R7 sys low
        '{1'b1, 1'b1, 8'd20,        1'b1, 1'b1}, // R3 long tick run
        '{1'b0, 1'b0, 8'd0,         1'b0, 1'b0}, // R2 both fall
        '{1'b0, 1'b0, 8'd30,        1'b0, 1'b0}  // R6 steady low
    };

    // Compare one value and report a failure line.
    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue a number of one-cycle tick pulses.
    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    // Drive inputs, let them settle, then apply ticks.
    task automatic apply(input logic r, input logic s, input int n);
        @(negedge clk);
        brd_rsm_pg = r;
        brd_sys_pg = s;
        repeat (4) @(negedge clk);
        pulse_ticks(n);
        @(negedge clk);
    endtask

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsm_out", 8'(cpu_rsm_pg), 8'd0);
        check("R1", "sys_out", 8'(cpu_sys_pwrok), 8'd0);
        check("R1", "match", 8'(chan_match), 8'd3);
        check("R1", "edge", 8'(chan_edge), 8'd0);

        // Vector walk (R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].rsm, VECS[i].sys, int'(VECS[i].ticks));
            check("R3/R5/R6", $sformatf("v%0d rsm_out", i), 8'(cpu_rsm_pg), 8'(VECS[i].e_rsm));
            check("R4/R7", $sformatf("v%0d sys_out", i), 8'(cpu_sys_pwrok), 8'(VECS[i].e_sys));
            check("R8", $sformatf("v%0d match", i), 8'(chan_match),
                  8'({VECS[i].e_sys == VECS[i].sys, VECS[i].e_rsm == VECS[i].rsm}));
        end

        // Bring both outputs high for the fall-timing test
        apply(1'b1, 1'b1, HOLD_S);
        check("R3", "both high", 8'({cpu_sys_pwrok, cpu_rsm_pg}), 8'd3);

        // R2 / R9: exact fall timing and single-cycle edge pulse
        @(negedge clk) brd_rsm_pg = 1'b0;
        @(negedge clk);
        check("R2", "rsm still high after 1 edge", 8'(cpu_rsm_pg), 8'd1);
        @(negedge clk);
        check("R2", "rsm still high after 2 edges", 8'(cpu_rsm_pg), 8'd1);
        check("R8", "mismatch while syncing", 8'(chan_match), 8'b10);
        @(negedge clk);
        check("R2", "rsm low after 3 edges", 8'(cpu_rsm_pg), 8'd0);
        check("R9", "edge pulse", 8'(chan_edge), 8'b01);
        check("R7", "sys unaffected", 8'(cpu_sys_pwrok), 8'd1);
        @(negedge clk);
        check("R9", "edge cleared", 8'(chan_edge), 8'b00);

        // R1: reset during a count clears it
        apply(1'b1, 1'b1, 5);
        check("R2", "sys fall skipped? sys", 8'(cpu_sys_pwrok), 8'd1);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "rsm low in reset", 8'(cpu_rsm_pg), 8'd0);
        check("R1", "sys low in reset", 8'(cpu_sys_pwrok), 8'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        pulse_ticks(HOLD_R - 1);
        @(negedge clk);
        check("R1", "count restarted after reset", 8'(cpu_rsm_pg), 8'd0);
        pulse_ticks(1);
        @(negedge clk);
        check("R3", "rsm high after full hold", 8'(cpu_rsm_pg), 8'd1);

        // R9: rising edge pulse is one cycle on the tick edge
        pulse_ticks(HOLD_S - HOLD_R - 1);
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
        check("R9", "rise edge pulse", 8'(chan_edge), 8'b10);
        check("R4", "sys high after its delay", 8'(cpu_sys_pwrok), 8'd1);
        @(negedge clk);
        check("R9", "rise edge cleared", 8'(chan_edge), 8'b00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule